// File: doc/BRIEF.md
# Card Command Issue Unit

This unit sends one command to a memory card and records what comes back. Software writes a control word and a 32-bit argument. The control word holds a 6-bit command index, a response-expected flag, a long-response flag, an interrupt-mode flag, a pending-mode flag and an enable bit. A write made while the unit is idle stores the control word. If the enable bit is set, the unit holds a request towards the card-side responder until that responder answers. The answer carries an error flag, a byte count and up to sixteen response bytes.

The unit checks the byte count against the response type that was asked for. A valid reply is packed big-endian into four 32-bit response words. A status flag then records the outcome: command sent, response received, or timeout. At that moment the enable bit in the stored control word clears itself, and a one-cycle pulse tells the data engine to try any transfer it has armed. While a command is in flight, `busy` is high and new control writes are dropped.

Top module: `card_cmd_issuer`

## Requirements
- R1: A control write with enable (bit 10) set while idle stores the word and the argument. `busy` and `reqValid` are high from the next cycle. `reqIndex` shows control bits 5:0 and `reqArg` shows the stored argument.
- R2: When bit 6 (response expected) is clear and the responder reports no error, only the sent flag (`cmdStatus` bit 7) is set. The response words are left unchanged.
- R3: The timeout flag (`cmdStatus` bit 2) is set in any of these cases: the responder reports an error; a response is expected and the byte count is neither 4 nor 16 (this includes 0); or a long response (bit 7) is expected and 4 bytes return. The response words are left unchanged.
- R4: A valid response sets only the response flag (`cmdStatus` bit 6). Word 0 (`respWords[31:0]`) is bytes 0 to 3, with byte 0 most significant. Byte i is `rspBytes[8i+7:8i]`.
- R5: A valid 4-byte response clears words 1 to 3 to zero.
- R6: A valid 16-byte response loads words 1, 2 and 3 (`respWords[32k+31:32k]`) from bytes 4k to 4k+3, big-endian. Bit 0 of word 3 is forced to zero.
- R7: When the reply is captured, `busy` drops, the status flags update and the stored enable bit clears, all in the same cycle. All status flags are cleared when an enabled command is accepted.
- R8: With pending mode (bit 9) set, no request is raised. The unit is busy for one cycle, clears its enable bit and leaves every status flag clear.
- R9: The interrupt-mode bit (bit 8) does not change how a command is issued or how it completes.
- R10: `dataKick` pulses for exactly one cycle, in the cycle the status of an issued command appears. A pending-mode command gives no pulse.
- R11: A control write while `busy` is ignored: the stored word, argument and request fields do not change.
- R12: A control write with enable clear stores the word but issues nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdWrite | input | 1 | Control-word write strobe |
| ctrlWord | input | 11 | Control word being written |
| cmdArg | input | 32 | Command argument, captured with the control word |
| busy | output | 1 | Command in flight |
| ctrlReg | output | 11 | Stored control word |
| reqValid | output | 1 | Request held towards the card responder |
| reqIndex | output | 6 | Command index of the request |
| reqArg | output | 32 | Argument of the request |
| rspValid | input | 1 | Responder answer strobe |
| rspError | input | 1 | Responder reports failure |
| rspLen | input | 5 | Number of response bytes returned |
| rspBytes | input | 128 | Response bytes, byte i at bits 8i+7:8i |
| respWords | output | 128 | Four response words, word k at bits 32k+31:32k |
| cmdStatus | output | 8 | Outcome flags: bit 2 timeout, bit 6 response, bit 7 sent |
| dataKick | output | 1 | One-cycle prompt to the data engine |

## Verification
A write sampled at one clock edge makes `busy`, `reqValid` and the request fields visible one cycle later. The responder answer sampled at an edge makes the status, the response words, the cleared enable bit, the fall of `busy` and the `dataKick` pulse all visible immediately after that same edge. `dataKick` is low again one cycle later. The bench drives every stimulus on the falling edge and samples on the next falling edge, so each result is read in the half-cycle after the edge that produces it. The sweep covers every combination of response-expected, long-response, responder error and byte count 0 to 16. Its expected outcomes and words are computed arithmetically from the byte pattern, and the word model carries the previous contents forward across timeouts.

// File: rtl/card_cmd_pkg.sv
package card_cmd_pkg;
  localparam int CTRL_W   = 11;
  localparam int IDX_W    = 6;
  localparam int RESP_BIT = 6;
  localparam int LONG_BIT = 7;
  localparam int INTR_BIT = 8;
  localparam int PEND_BIT = 9;
  localparam int EN_BIT   = 10;

  localparam int STAT_W     = 8;
  localparam int ST_TIMEOUT = 2;
  localparam int ST_RESPEND = 6;
  localparam int ST_SENT    = 7;

  typedef struct packed {
    logic load;     // store control word and argument
    logic launch;   // clear outcome flags for a new command
    logic capture;  // take the responder answer
    logic retire;   // drop the enable bit
  } cmd_strobe_t;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_DROP} cmd_state_t;
endpackage

// File: rtl/card_cmd_ctrl.sv
module card_cmd_ctrl
  import card_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWrite,
  input  logic        wrEnable,
  input  logic        wrPending,
  input  logic        rspValid,
  output cmd_strobe_t strb,
  output logic        busy,
  output logic        reqValid,
  output logic        dataKick
);
  cmd_state_t state, stateNext;
  logic kickQ;

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      S_IDLE: if (cmdWrite) begin
        strb.load = 1'b1;
        if (wrEnable) begin
          strb.launch = 1'b1;
          stateNext   = wrPending ? S_DROP : S_WAIT;
        end
      end
      S_WAIT: if (rspValid) begin
        strb.capture = 1'b1;
        strb.retire  = 1'b1;
        stateNext    = S_IDLE;
      end
      S_DROP: begin
        strb.retire = 1'b1;
        stateNext   = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      kickQ <= 1'b0;
    end else begin
      state <= stateNext;
      kickQ <= strb.capture;
    end
  end

  assign busy     = (state != S_IDLE);
  assign reqValid = (state == S_WAIT);
  assign dataKick = kickQ;

  AST_KICK_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    dataKick |-> !busy && $past(reqValid)); // R10
endmodule

// File: rtl/card_cmd_dpath.sv
module card_cmd_dpath
  import card_cmd_pkg::*;
#(
  parameter int ARG_W       = 32,
  parameter int RESP_BYTES  = 16,
  parameter int SHORT_BYTES = 4,
  localparam int NWORDS     = RESP_BYTES / 4,
  localparam int LEN_W      = $clog2(RESP_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  cmd_strobe_t             strb,
  input  logic [CTRL_W-1:0]       ctrlIn,
  input  logic [ARG_W-1:0]        argIn,
  input  logic                    rspError,
  input  logic [LEN_W-1:0]        rspLen,
  input  logic [8*RESP_BYTES-1:0] rspBytes,
  output logic [CTRL_W-1:0]       ctrlReg,
  output logic [ARG_W-1:0]        argReg,
  output logic [32*NWORDS-1:0]    respWords,
  output logic [STAT_W-1:0]       status
);
  logic [32*NWORDS-1:0] packedWords, nextWords;
  logic wantResp, wantLong, isShort, isLong, badLen, timeoutHit;

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    assign packedWords[32*k +: 32] = {rspBytes[8*(4*k)   +: 8], rspBytes[8*(4*k+1) +: 8],
                                      rspBytes[8*(4*k+2) +: 8], rspBytes[8*(4*k+3) +: 8]};
  end

  always_comb begin
    nextWords = packedWords;
    if (isShort) nextWords[32*NWORDS-1:32] = '0;
    nextWords[32*(NWORDS-1)] = 1'b0;
  end

  assign wantResp   = ctrlReg[RESP_BIT];
  assign wantLong   = ctrlReg[LONG_BIT];
  assign isShort    = (rspLen == LEN_W'(SHORT_BYTES));
  assign isLong     = (rspLen == LEN_W'(RESP_BYTES));
  assign badLen     = (!isShort && !isLong) || (isShort && wantLong);
  assign timeoutHit = rspError || (wantResp && badLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      argReg    <= '0;
      respWords <= '0;
      status    <= '0;
    end else begin
      if (strb.load) begin
        ctrlReg <= ctrlIn;
        argReg  <= argIn;
      end
      if (strb.launch) status <= '0;
      if (strb.capture) begin
        if (timeoutHit) status[ST_TIMEOUT] <= 1'b1;
        else if (wantResp) begin
          status[ST_RESPEND] <= 1'b1;
          respWords          <= nextWords;
        end else status[ST_SENT] <= 1'b1;
      end
      if (strb.retire) ctrlReg[EN_BIT] <= 1'b0;
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    $countones({status[ST_TIMEOUT], status[ST_RESPEND], status[ST_SENT]}) <= 1); // R3
endmodule

// File: rtl/card_cmd_issuer.sv
module card_cmd_issuer
  import card_cmd_pkg::*;
#(
  parameter int ARG_W      = 32,
  parameter int RESP_BYTES = 16,
  localparam int NWORDS    = RESP_BYTES / 4,
  localparam int LEN_W     = $clog2(RESP_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmdWrite,
  input  logic [CTRL_W-1:0]       ctrlWord,
  input  logic [ARG_W-1:0]        cmdArg,
  output logic                    busy,
  output logic [CTRL_W-1:0]       ctrlReg,
  output logic                    reqValid,
  output logic [IDX_W-1:0]        reqIndex,
  output logic [ARG_W-1:0]        reqArg,
  input  logic                    rspValid,
  input  logic                    rspError,
  input  logic [LEN_W-1:0]        rspLen,
  input  logic [8*RESP_BYTES-1:0] rspBytes,
  output logic [32*NWORDS-1:0]    respWords,
  output logic [STAT_W-1:0]       cmdStatus,
  output logic                    dataKick
);
  cmd_strobe_t strb;

  card_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite),
    .wrEnable(ctrlWord[EN_BIT]), .wrPending(ctrlWord[PEND_BIT]),
    .rspValid(rspValid), .strb(strb), .busy(busy),
    .reqValid(reqValid), .dataKick(dataKick)
  );

  card_cmd_dpath #(.ARG_W(ARG_W), .RESP_BYTES(RESP_BYTES)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .ctrlIn(ctrlWord), .argIn(cmdArg),
    .rspError(rspError), .rspLen(rspLen), .rspBytes(rspBytes),
    .ctrlReg(ctrlReg), .argReg(reqArg), .respWords(respWords), .status(cmdStatus)
  );

  assign reqIndex = ctrlReg[IDX_W-1:0];

  AST_EN_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !ctrlReg[EN_BIT]); // R7
  AST_REQ_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> ctrlReg[EN_BIT] && !ctrlReg[PEND_BIT]); // R8
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && $past(reqValid) |-> $stable(reqArg) && $stable(reqIndex)); // R11
endmodule

// File: tb/card_cmd_issuer_test.sv
module card_cmd_issuer_test;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cmdWrite = 1'b0;
  logic [10:0]  ctrlWord = '0;
  logic [31:0]  cmdArg = '0;
  logic         busy, reqValid, dataKick;
  logic [10:0]  ctrlReg;
  logic [5:0]   reqIndex;
  logic [31:0]  reqArg;
  logic         rspValid = 1'b0, rspError = 1'b0;
  logic [4:0]   rspLen = '0;
  logic [127:0] rspBytes = '0;
  logic [127:0] respWords;
  logic [7:0]   cmdStatus;

  int checks = 0, errors = 0;
  logic [127:0] expWords = '0;

  always #10 clk = ~clk;

  card_cmd_issuer uut (.*);

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] byteOf(int seed, int i);
    return 8'((seed * 13 + i * 29 + 5) & 255);
  endfunction

  task automatic doCmd(string tag, logic [10:0] ctrl, logic [31:0] arg, int n,
                       logic err, int seed, int delay);
    logic wantResp, wantLong, valid, tmo;
    logic [7:0] expStat;
    @(negedge clk);
    cmdWrite = 1'b1; ctrlWord = ctrl; cmdArg = arg;
    @(negedge clk);
    cmdWrite = 1'b0;
    chk("R1 busy", 128'(busy), 128'(1));
    chk("R1 reqValid", 128'(reqValid), 128'(1));
    chk("R1 reqIndex", 128'(reqIndex), 128'(ctrl[5:0]));
    chk("R1 reqArg", 128'(reqArg), 128'(arg));
    if (delay > 0) begin
      cmdWrite = 1'b1; ctrlWord = ~ctrl | 11'h400; cmdArg = ~arg;
      @(negedge clk);
      cmdWrite = 1'b0;
      chk("R11 reqIndex while busy", 128'(reqIndex), 128'(ctrl[5:0]));
      chk("R11 reqArg while busy", 128'(reqArg), 128'(arg));
      repeat (delay - 1) @(negedge clk);
    end
    for (int i = 0; i < 16; i++) rspBytes[8*i +: 8] = byteOf(seed, i);
    rspLen = 5'(n); rspError = err; rspValid = 1'b1;
    @(negedge clk);
    rspValid = 1'b0;
    wantResp = ctrl[6]; wantLong = ctrl[7];
    valid = (n == 16) || (n == 4 && !wantLong);
    tmo = err || (wantResp && !valid);
    expStat = tmo ? 8'h04 : (wantResp ? 8'h40 : 8'h80);
    if (!tmo && wantResp) begin
      for (int k = 0; k < 4; k++)
        expWords[32*k +: 32] = (n == 4 && k > 0) ? 32'h0 :
          {byteOf(seed, 4*k), byteOf(seed, 4*k+1), byteOf(seed, 4*k+2), byteOf(seed, 4*k+3)};
      expWords[96] = 1'b0;
    end
    chk({tag, " status"}, 128'(cmdStatus), 128'(expStat));
    chk({tag, " words"}, respWords, expWords);
    chk("R7 busy drops", 128'(busy), 128'(0));
    chk("R7 R11 ctrlReg enable cleared", 128'(ctrlReg), 128'(ctrl & 11'h3FF));
    chk("R10 kick high", 128'(dataKick), 128'(1));
    @(negedge clk);
    chk("R10 kick one cycle", 128'(dataKick), 128'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R7 reset busy", 128'(busy), 128'(0));
    chk("R7 reset status", 128'(cmdStatus), 128'(0));
    chk("R1 reset ctrl", 128'(ctrlReg), 128'(0));
    chk("R4 reset words", respWords, 128'(0));
    // Sweep: response expected, long, error, every length 0..16.
    for (int e = 0; e < 2; e++)
      for (int l = 0; l < 2; l++)
        for (int r = 0; r < 2; r++)
          for (int n = 0; n <= 16; n++) begin
            string tag;
            int seed;
            seed = e * 71 + l * 37 + r * 11 + n * 3;
            tag = (r == 1 || (e == 1 && !(n == 16 || (n == 4 && l == 0)))) ? "R3" :
                  (e == 0) ? "R2" : (n == 4) ? "R4 R5" : "R4 R6";
            doCmd(tag, 11'(11'h400 | (e << 6) | (l << 7) | (seed & 63)),
                  32'(32'hA5000000 + seed * 977), n, 1'(r), seed, n % 3);
          end
    // Interrupt mode bit behaves like a normal issue.
    doCmd("R9 long", 11'h400 | 11'h100 | 11'h0C0 | 11'h11, 32'h1234_5678, 16, 1'b0, 200, 1);
    doCmd("R9 nores", 11'h400 | 11'h100 | 11'h02, 32'h0, 4, 1'b0, 201, 0);
    // Pending mode: no request, flags cleared, no kick.
    @(negedge clk);
    cmdWrite = 1'b1; ctrlWord = 11'h600 | 11'h040 | 11'h09; cmdArg = 32'hDEAD_BEEF;
    @(negedge clk);
    cmdWrite = 1'b0;
    chk("R8 pending busy", 128'(busy), 128'(1));
    chk("R8 pending no request", 128'(reqValid), 128'(0));
    @(negedge clk);
    chk("R8 pending idle", 128'(busy), 128'(0));
    chk("R8 pending status clear", 128'(cmdStatus), 128'(0));
    chk("R8 pending enable cleared", 128'(ctrlReg), 128'(11'h249));
    chk("R10 no kick for pending", 128'(dataKick), 128'(0));
    chk("R8 words kept", respWords, expWords);
    // Write without enable.
    cmdWrite = 1'b1; ctrlWord = 11'h0C5; cmdArg = 32'h5555_0000;
    @(negedge clk);
    cmdWrite = 1'b0;
    chk("R12 stored", 128'(ctrlReg), 128'(11'h0C5));
    chk("R12 not busy", 128'(busy), 128'(0));
    chk("R12 no request", 128'(reqValid), 128'(0));
    @(negedge clk);
    chk("R12 still idle", 128'(reqValid), 128'(0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule